// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the time base for a pulse-width modulator. A 16-bit counter advances once per prescaled tick. The tick comes from the input clock through two divider stages in series: a power-of-two stage, and a stage that divides by one or by an even number. The counter can count up, count down, count up then down, or hold its value.

Downstream compare and action logic uses the count, the active period, the direction flag and two single-cycle event strobes. One strobe fires when the count arrives at zero and the other when it arrives at the period. Software programs the block through a small write port that has a control word and a period register. The period can be written straight into the active copy. It can also be staged in a shadow copy that takes effect the next time the count reaches zero, so a running waveform never sees a torn cycle. A run field freezes the counter at once, lets it finish the current cycle and then halt, or lets it run freely.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count, the active period, the shadow period, the direction flag and both event strobes are zero. The control word is zero: run field 00 (counter stopped), up-count mode, shadowed period, both dividers at their smallest setting.
- R2: The control word holds two divider fields. Bits 12:10 hold the coarse field c and bits 9:7 hold the fine field f. The prescale ratio is 2^c times (1 when f is 0, otherwise 2f). `tick_o` is high for one clock in every ratio clocks.
- R3: A control write that changes any bit in 12:7 restarts the prescaler phase, so the next tick comes ratio clocks after that write. A control write that leaves bits 12:7 unchanged does not disturb the phase.
- R4: Mode 00 in bits 1:0 is up-count. Each tick the count rises by one. A tick that finds the count at or above the active period sends it to 0.
- R5: Mode 01 is down-count. Each tick the count falls by one. A tick that finds the count at 0 loads the active period.
- R6: Mode 10 is up-down count. While rising, a tick at or above the period turns the count downward (it steps by minus one and `dir_o` becomes 1). While falling, a tick at 0 turns it upward (the count becomes 1 and `dir_o` becomes 0). With a period of 0 the count stays at 0.
- R7: Mode 11 freezes the count. Ticks leave it unchanged and no event strobe fires.
- R8: Run field bits 15:14 set to 00 stop the counter immediately. Values 10 and 11 let it run freely.
- R9: Run field 01 lets the counter keep advancing until a tick brings the count to 0. The counter then holds until the next control-word write.
- R10: Bit 3 of the control word set to 0 selects shadowed loading. A period write updates only the shadow copy, and the active period takes the shadow value on the tick that brings the count to 0.
- R11: Bit 3 set to 1 selects immediate loading. A period write updates both the active and the shadow copy on the clock edge of the write.
- R12: `zero_evt_o` is high for exactly the one clock in which `count_o` first shows 0 after an advancing tick. `prd_evt_o` is high for the one clock in which `count_o` first shows the period in force after that tick. Both fire together when the period is 0.
- R13: A write to offset 0x0 loads the control word and a write to offset 0xA loads the period. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register offset of the write |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| period_o | output | 16 | Active period |
| dir_o | output | 1 | Count direction, 1 when counting down |
| tick_o | output | 1 | Prescaled counting tick |
| zero_evt_o | output | 1 | Count arrived at zero |
| prd_evt_o | output | 1 | Count arrived at the period |

## Verification
A prescaler phase error shows at `tick_o` within one divide ratio and shifts every later count step by the same number of clocks. A wrong direction flag or turning decision changes `count_o` on the very next tick. A stale or early period reload shows up one cycle later as a wrap at the wrong value and a misplaced `prd_evt_o`. A halt flag that is stuck or is never set shows up within one counter cycle, because the count either sticks at zero when it should restart or keeps moving when it should hold.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int unsigned RUN_LO    = 14;
  localparam int unsigned COARSE_LO = 10;
  localparam int unsigned FINE_LO   = 7;
  localparam int unsigned IMM_BIT   = 3;
  localparam int unsigned MODE_LO   = 0;

  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_FREEZE = 2'b11
  } cnt_mode_e;

  localparam logic [1:0] RUN_STOP  = 2'b00;
  localparam logic [1:0] RUN_CYCLE = 2'b01;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int unsigned CDIV_W = 3,
  parameter int unsigned FDIV_W = 3,
  localparam int unsigned PS_W  = (1 << CDIV_W) - 1 + FDIV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CDIV_W-1:0] coarse_i,
  input  logic [FDIV_W-1:0] fine_i,
  input  logic              restart_i,
  output logic              tick_o
);
  logic [PS_W-1:0] fine_mult, ratio, presc_q;

  always_comb begin
    if (fine_i == '0) fine_mult = PS_W'(1);
    else              fine_mult = {{(PS_W-FDIV_W-1){1'b0}}, fine_i, 1'b0};
    ratio = fine_mult << coarse_i;
  end

  assign tick_o = (presc_q == ratio - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        presc_q <= '0;
    else if (restart_i) presc_q <= '0;
    else if (tick_o)    presc_q <= '0;
    else                presc_q <= presc_q + 1'b1;
  end

  assert_phase_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> presc_q == '0);
  assert_phase_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_q < ratio);
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         imm_i,
  input  logic         reload_i,
  output logic [W-1:0] active_o,
  output logic [W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      shadow_o <= '0;
    end else begin
      if (wr_i) shadow_o <= data_i;
      if (wr_i && imm_i) active_o <= data_i;
      else if (reload_i) active_o <= shadow_o;
    end
  end

  assert_imm_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && imm_i) |=> active_o == $past(data_i));
  assert_shadow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !(wr_i && imm_i)) |=> $stable(active_o));
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  cnt_mode_e    mode_i,
  input  logic [1:0]   run_i,
  input  logic         ctrl_wr_i,
  input  logic         shadow_mode_i,
  input  logic [W-1:0] active_prd_i,
  input  logic [W-1:0] shadow_prd_i,
  output logic [W-1:0] count_o,
  output logic         dir_o,
  output logic         zero_evt_o,
  output logic         prd_evt_o,
  output logic         reload_o
);
  logic         halt_q, run_ok, adv, dir_nxt;
  logic [W-1:0] nxt, prd_cmp;

  assign run_ok = run_i[1] | ((run_i == RUN_CYCLE) & ~halt_q);
  assign adv    = tick_i & run_ok & (mode_i != CM_FREEZE);

  always_comb begin
    nxt     = count_o;
    dir_nxt = dir_o;
    unique case (mode_i)
      CM_UP: begin
        dir_nxt = 1'b0;
        nxt     = (count_o >= active_prd_i) ? '0 : count_o + 1'b1;
      end
      CM_DOWN: begin
        dir_nxt = 1'b1;
        nxt     = (count_o == '0) ? active_prd_i : count_o - 1'b1;
      end
      CM_UPDOWN: begin
        if (active_prd_i == '0) begin
          nxt     = '0;
          dir_nxt = 1'b0;
        end else if (!dir_o) begin
          if (count_o >= active_prd_i) begin
            nxt     = count_o - 1'b1;
            dir_nxt = 1'b1;
          end else begin
            nxt = count_o + 1'b1;
          end
        end else begin
          if (count_o == '0) begin
            nxt     = W'(1);
            dir_nxt = 1'b0;
          end else begin
            nxt = count_o - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign reload_o = adv & (nxt == '0) & shadow_mode_i;
  assign prd_cmp  = reload_o ? shadow_prd_i : active_prd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o    <= '0;
      dir_o      <= 1'b0;
      halt_q     <= 1'b0;
      zero_evt_o <= 1'b0;
      prd_evt_o  <= 1'b0;
    end else begin
      if (adv) begin
        count_o <= nxt;
        dir_o   <= dir_nxt;
      end
      if (ctrl_wr_i) halt_q <= 1'b0;
      else if ((run_i == RUN_CYCLE) && adv && (nxt == '0)) halt_q <= 1'b1;
      zero_evt_o <= adv & (nxt == '0);
      prd_evt_o  <= adv & (nxt == prd_cmp);
    end
  end

  assert_up_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_UP && count_o >= active_prd_i) |=> count_o == '0);
  assert_down_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_DOWN && count_o == '0) |=> count_o == $past(active_prd_i));
  assert_turn_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == CM_UPDOWN && !dir_o && active_prd_i != '0 && count_o >= active_prd_i)
      |=> dir_o);
  assert_freeze_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_FREEZE) |=> ($stable(count_o) && !zero_evt_o && !prd_evt_o));
  assert_stop_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i == RUN_STOP) |=> $stable(count_o));
  assert_halt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && run_i == RUN_CYCLE) |=> $stable(count_o));
  assert_zero_evt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt_o |-> count_o == '0);
  assert_prd_evt_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_evt_o |-> $past(tick_i));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CDIV_W   = 3,
  parameter int unsigned FDIV_W   = 3,
  parameter logic [3:0]  CTRL_OFS = 4'h0,
  parameter logic [3:0]  PRD_OFS  = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  count_o,
  output logic [REG_W-1:0]  period_o,
  output logic              dir_o,
  output logic              tick_o,
  output logic              zero_evt_o,
  output logic              prd_evt_o
);
  localparam int unsigned DIV_HI = COARSE_LO + CDIV_W - 1;

  logic              ctrl_wr, prd_wr, restart, reload;
  logic [1:0]        run_q;
  logic [CDIV_W-1:0] coarse_q;
  logic [FDIV_W-1:0] fine_q;
  logic              imm_q;
  cnt_mode_e         mode_q;
  logic [REG_W-1:0]  shadow_prd;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_OFS));
  assign prd_wr  = wr_en_i && (wr_addr_i == ADDR_W'(PRD_OFS));
  assign restart = ctrl_wr && (wr_data_i[DIV_HI:FINE_LO] != {coarse_q, fine_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= RUN_STOP;
      coarse_q <= '0;
      fine_q   <= '0;
      imm_q    <= 1'b0;
      mode_q   <= CM_UP;
    end else if (ctrl_wr) begin
      run_q    <= wr_data_i[RUN_LO+1:RUN_LO];
      coarse_q <= wr_data_i[COARSE_LO+CDIV_W-1:COARSE_LO];
      fine_q   <= wr_data_i[FINE_LO+FDIV_W-1:FINE_LO];
      imm_q    <= wr_data_i[IMM_BIT];
      mode_q   <= cnt_mode_e'(wr_data_i[MODE_LO+1:MODE_LO]);
    end
  end

  pwm_tb_prescaler #(.CDIV_W(CDIV_W), .FDIV_W(FDIV_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .coarse_i  (coarse_q),
    .fine_i    (fine_q),
    .restart_i (restart),
    .tick_o    (tick_o)
  );

  pwm_tb_period #(.W(REG_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (prd_wr),
    .data_i   (wr_data_i),
    .imm_i    (imm_q),
    .reload_i (reload),
    .active_o (period_o),
    .shadow_o (shadow_prd)
  );

  pwm_tb_counter #(.W(REG_W)) u_counter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_o),
    .mode_i        (mode_q),
    .run_i         (run_q),
    .ctrl_wr_i     (ctrl_wr),
    .shadow_mode_i (~imm_q),
    .active_prd_i  (period_o),
    .shadow_prd_i  (shadow_prd),
    .count_o       (count_o),
    .dir_o         (dir_o),
    .zero_evt_o    (zero_evt_o),
    .prd_evt_o     (prd_evt_o),
    .reload_o      (reload)
  );

  assert_decode_ignore_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable({run_q, coarse_q, fine_q, imm_q, mode_q}));
  assert_ctrl_load_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> run_q == $past(wr_data_i[RUN_LO+1:RUN_LO]));
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] count_o, period_o;
  logic        dir_o, tick_o, zero_evt_o, prd_evt_o;

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_timebase dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .period_o(period_o), .dir_o(dir_o),
    .tick_o(tick_o), .zero_evt_o(zero_evt_o), .prd_evt_o(prd_evt_o)
  );

  typedef struct {
    int    cnt;
    int    prd;
    bit    dir;
    bit    zev;
    bit    pev;
    bit    tk;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit [15:0] m_ctrl = '0;
  int m_pc = 0, m_cnt = 0, m_shd = 0, m_act = 0;
  bit m_dir = 0, m_halt = 0;

  function automatic int ratio_of(bit [15:0] c);
    int f = c[9:7];
    return (1 << c[12:10]) * ((f == 0) ? 1 : 2 * f);
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      int dv, nx, pcmp, old_shd;
      bit tk, rok, adv, nd, rl, zev, pev, cw, pw;
      bit [1:0] md;
      exp_t it;
      cw = wr_en_i && wr_addr_i == 4'h0;
      pw = wr_en_i && wr_addr_i == 4'hA;
      dv = ratio_of(m_ctrl);
      tk = (m_pc == dv - 1);
      rok = m_ctrl[15] || (m_ctrl[15:14] == 2'b01 && !m_halt);
      md = m_ctrl[1:0];
      adv = tk && rok && md != 2'b11;
      nx = m_cnt; nd = m_dir;
      case (md)
        2'b00: begin nd = 0; nx = (m_cnt >= m_act) ? 0 : m_cnt + 1; end
        2'b01: begin nd = 1; nx = (m_cnt == 0) ? m_act : m_cnt - 1; end
        2'b10: begin
          if (m_act == 0) begin nx = 0; nd = 0; end
          else if (!m_dir) begin
            if (m_cnt >= m_act) begin nx = m_cnt - 1; nd = 1; end
            else nx = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin nx = 1; nd = 0; end
            else nx = m_cnt - 1;
          end
        end
        default: ;
      endcase
      rl = adv && nx == 0 && !m_ctrl[3];
      pcmp = rl ? m_shd : m_act;
      zev = adv && nx == 0;
      pev = adv && nx == pcmp;
      if (cw) m_halt = 0;
      else if (m_ctrl[15:14] == 2'b01 && adv && nx == 0) m_halt = 1;
      if (adv) begin m_cnt = nx; m_dir = nd; end
      old_shd = m_shd;
      if (pw) m_shd = wr_data_i;
      if (pw && m_ctrl[3]) m_act = wr_data_i;
      else if (rl) m_act = old_shd;
      if (cw && wr_data_i[12:7] != m_ctrl[12:7]) m_pc = 0;
      else if (tk) m_pc = 0;
      else m_pc++;
      if (cw) m_ctrl = wr_data_i;
      it.cnt = m_cnt; it.prd = m_act; it.dir = m_dir;
      it.zev = zev; it.pev = pev;
      it.tk = (m_pc == ratio_of(m_ctrl) - 1);
      it.tag = cur_tag;
      sb_q.push_back(it);
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "count", int'(count_o), e.cnt);
      chk(e.tag, "period", int'(period_o), e.prd);
      chk("R6", "dir", int'(dir_o), int'(e.dir));
      chk("R2", "tick", int'(tick_o), int'(e.tk));
      chk("R12", "zero_evt", int'(zero_evt_o), int'(e.zev));
      chk("R12", "prd_evt", int'(prd_evt_o), int'(e.pev));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    @(negedge clk_i);
    cur_tag = tag;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "period", int'(period_o), 0);
    chk("R1", "zero_evt", int'(zero_evt_o), 0);
    chk("R1", "prd_evt", int'(prd_evt_o), 0);
    chk("R1", "dir", int'(dir_o), 0);
    rst_ni = 1'b1;
    idle(4);
    wr(4'hA, 16'd5, "R10");          // shadow only, counter stopped
    idle(6);
    wr(4'h0, 16'hC000, "R4");        // free run, up, shadow, ratio 1
    idle(30);
    wr(4'h4, 16'hFFFF, "R13");       // unmapped offset
    idle(10);
    wr(4'h0, 16'hC008, "R11");
    wr(4'hA, 16'd3, "R11");
    idle(15);
    wr(4'h0, 16'hC009, "R5");        // down
    idle(20);
    wr(4'h0, 16'hC00A, "R6");        // up-down
    idle(24);
    wr(4'h0, 16'hC00B, "R7");        // freeze
    idle(10);
    wr(4'h0, 16'hC488, "R2");        // ratio 2*2=4, up
    idle(30);
    wr(4'h0, 16'hC488, "R3");        // same dividers: phase kept
    idle(9);
    wr(4'h0, 16'hC188, "R3");        // ratio 6: phase restarts
    idle(40);
    wr(4'h0, 16'hC008, "R9");
    wr(4'hA, 16'd4, "R9");
    idle(3);
    wr(4'h0, 16'h4008, "R9");        // finish cycle then halt
    idle(20);
    wr(4'h0, 16'h0008, "R8");        // stop at once
    idle(10);
    wr(4'h0, 16'h8008, "R8");        // run field 10 runs freely
    idle(12);
    wr(4'h0, 16'hC002, "R10");       // up-down, shadow
    idle(3);
    wr(4'hA, 16'd7, "R10");
    idle(40);
    wr(4'hA, 16'd0, "R12");          // zero period: both strobes
    idle(30);
    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule